// File: doc/BRIEF.md
# I2C Slave Port with Host-Visible Status Flags

This block joins a two-wire serial bus as a 7-bit-addressed slave and gives a local host a small synchronous register port. It watches the clock and data lines through a resynchronising stage and detects bus start and stop conditions. It takes in the first byte after a start and compares its upper seven bits with a programmable own address. The last bit of that byte chooses the direction. A 0 makes the slave a receiver that acknowledges each byte and places it in a receive register. A 1 makes it a transmitter that shifts out words the host has queued.

The transmit side is two words deep: a front word that goes out next and a back word behind it. The transmit-ready flag reports only whether a free slot exists. It does not depend on whether the slave is addressed, or in which direction. When both slots are full, another host write replaces the front word, so the newest value is the next byte on the wire. The data line is modelled as an open-drain pull-down: the block asserts an enable to pull it low and otherwise leaves it released.

Top module: `i2c_slave_port`

## Requirements
- R1: After reset the status register (host offset 2) reads 0x08. That means bus-busy (bit 0) = 0, addressed (bit 1) = 0, receive-ready (bit 2) = 0, transmit-ready (bit 3) = 1 and transmitter (bit 4) = 0. The data-line pull-down is off.
- R2: Bus-busy becomes 1 after a start (data falling while clock is high). A stop (data rising while clock is high) clears both bus-busy and addressed. Addressed is never 1 while bus-busy is 0.
- R3: The first byte after a start is taken in most-significant bit first. When bits 7:1 equal the own address (control register offset 3, bits 6:0, reset value 0x2A), the slave sets addressed and pulls the line low in the ninth clock. On a mismatch it gives no acknowledge, leaves addressed at 0 and ignores all further bytes until the next start.
- R4: With R/W = 0, every data byte is acknowledged and stored at host offset 0, and receive-ready is set. A host read of offset 0 clears receive-ready.
- R5: Transmit-ready stays 1 while fewer than two words are queued, whether the slave is addressed for a read, addressed for a write or not addressed at all. It clears on the host write (offset 1) that fills the second slot.
- R6: Once low, transmit-ready stays low through addressing. It returns to 1 only after a byte has been shifted out to the master in a read transfer.
- R7: With R/W = 1, queued words are sent in write order, most-significant bit first. A master acknowledge continues the transfer. A master non-acknowledge ends it, and the slave drives nothing until the next start. The slave changes its drive only while the clock is low.
- R8: A host write while both slots are full replaces the front word, and that word is the next byte sent.
- R9: The direction bit (offset 3, bit 7) can be written and read back but has no effect: the received R/W bit alone picks the direction.
- R10: A repeated start keeps bus-busy at 1, clears addressed and re-enters address reception.
- R11: A byte requested with the transmit queue empty goes out as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, pull the data line low |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (side effect at offset 0) |
| reg_addr | input | 2 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for reg_addr |

## Verification
The bench tries every one of the 128 seven-bit addresses. A comparator that got a bit wrong would acknowledge a foreign address or miss its own. A slave that does not go silent after a mismatch would acknowledge the byte that follows. The transmit-ready flag is checked while the slave is unaddressed, addressed for writing and addressed for reading. A flag tied to the direction would fall early, or rise before a byte has gone out. A third host write onto a full queue has to appear as the first byte sent, and an empty queue has to send 0xFF. A repeated start has to keep the bus busy, and the data line has to stay released after a master non-acknowledge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] REG_RXD  = 2'd0;
  localparam logic [REG_AW-1:0] REG_TXD  = 2'd1;
  localparam logic [REG_AW-1:0] REG_STAT = 2'd2;
  localparam logic [REG_AW-1:0] REG_CTRL = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK, ST_WAIT
  } eng_state_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2,
  parameter int N      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_txbuf.sv
module i2cs_txbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] front,
  output logic         valid,
  output logic         ready
);
  logic [1:0]   cnt_q, cnt_d, c;
  logic [W-1:0] front_q, front_d, back_q, back_d;

  always_comb begin
    cnt_d   = cnt_q;
    front_d = front_q;
    back_d  = back_q;
    if (pop && cnt_q != 2'd0) begin
      front_d = back_q;
      cnt_d   = cnt_q - 2'd1;
    end
    c = cnt_d;
    if (wr) begin
      unique case (c)
        2'd0:    begin front_d = wdata; cnt_d = 2'd1; end
        2'd1:    begin back_d  = wdata; cnt_d = 2'd2; end
        default: front_d = wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= 2'd0;
      front_q <= '0;
      back_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      front_q <= front_d;
      back_q  <= back_d;
    end
  end

  assign front = front_q;
  assign valid = (cnt_q != 2'd0);
  assign ready = (cnt_q < 2'd2);
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = BYTE_W - 1,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              sda_oe,
  output logic              busy,
  output logic              aas,
  output logic              xmit,
  output logic              rx_stb,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              tx_pop
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  eng_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d, tx_word;
  logic              oe_q, oe_d, busy_q, busy_d, aas_q, aas_d;
  logic              rw_q, rw_d, mack_q, mack_d;
  logic              scl_q, sda_q;
  logic              scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign tx_word   = tx_valid ? tx_data : '1;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sr_d = sr_q; oe_d = oe_q;
    busy_d = busy_q; aas_d = aas_q; rw_d = rw_q; mack_d = mack_q;
    rx_stb = 1'b0; tx_pop = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE; busy_d = 1'b0; aas_d = 1'b0; oe_d = 1'b0; rw_d = 1'b0;
    end else if (start_det) begin
      st_d = ST_ADDR; busy_d = 1'b1; aas_d = 1'b0; oe_d = 1'b0;
      rw_d = 1'b0; cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sr_d = {sr_q[BYTE_W-2:0], sda_s}; cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            if (sr_q[BYTE_W-1 -: ADDR_W] == own_addr) begin
              st_d = ST_AACK; aas_d = 1'b1; oe_d = 1'b1; rw_d = sr_q[0];
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt_d = '0;
          if (rw_q) begin
            st_d = ST_TX; sr_d = tx_word; oe_d = ~tx_word[BYTE_W-1];
          end else begin
            st_d = ST_RX; oe_d = 1'b0;
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sr_d = {sr_q[BYTE_W-2:0], sda_s}; cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            rx_stb = 1'b1; st_d = ST_RACK; oe_d = 1'b1;
          end
        end
        ST_RACK: if (scl_fall) begin
          st_d = ST_RX; oe_d = 1'b0; cnt_d = '0;
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            st_d = ST_TACK; oe_d = 1'b0; tx_pop = 1'b1;
          end else if (scl_fall && cnt_q != '0) begin
            sr_d = {sr_q[BYTE_W-2:0], 1'b1}; oe_d = ~sr_q[BYTE_W-2];
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d = ST_TX; cnt_d = '0; sr_d = tx_word;
              oe_d = ~tx_word[BYTE_W-1];
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sr_q <= '0; oe_q <= 1'b0;
      busy_q <= 1'b0; aas_q <= 1'b0; rw_q <= 1'b0; mack_q <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sr_q <= sr_d; oe_q <= oe_d;
      busy_q <= busy_d; aas_q <= aas_d; rw_q <= rw_d; mack_q <= mack_d;
      scl_q <= scl_s; sda_q <= sda_s;
    end
  end

  assign sda_oe  = oe_q;
  assign busy    = busy_q;
  assign aas     = aas_q;
  assign xmit    = aas_q & rw_q;
  assign rx_byte = sr_q;
endmodule

// File: rtl/i2c_slave_port.sv
module i2c_slave_port
  import i2cs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-2:0] OWN_RESET = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata
);
  localparam int ADDR_W = BYTE_W - 1;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [1:0]        line_s;
  logic              scl_s, sda_s;
  logic [ADDR_W-1:0] own_q;
  logic              dir_q;
  logic [BYTE_W-1:0] rx_data_q, rx_byte, tx_front;
  logic              rx_ready_q, rx_ready_d;
  logic              tx_valid, tx_ready, tx_pop, tx_wr, rx_rd, ctrl_wr;
  logic              busy, aas, xmit, rx_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  i2cs_sync #(.STAGES(SYNC_STAGES), .N(2)) i_sync (
    .clk(clk), .rst_n(rst_int_n), .d({sda_i, scl_i}), .q(line_s)
  );
  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  assign tx_wr   = reg_wr && reg_addr == REG_TXD;
  assign ctrl_wr = reg_wr && reg_addr == REG_CTRL;
  assign rx_rd   = reg_rd && reg_addr == REG_RXD;

  i2cs_engine #(.BYTE_W(BYTE_W)) i_engine (
    .clk(clk), .rst_n(rst_int_n), .scl_s(scl_s), .sda_s(sda_s),
    .own_addr(own_q), .tx_data(tx_front), .tx_valid(tx_valid),
    .sda_oe(sda_oe), .busy(busy), .aas(aas), .xmit(xmit),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .tx_pop(tx_pop)
  );

  i2cs_txbuf #(.W(BYTE_W)) i_txbuf (
    .clk(clk), .rst_n(rst_int_n), .wr(tx_wr), .wdata(reg_wdata),
    .pop(tx_pop), .front(tx_front), .valid(tx_valid), .ready(tx_ready)
  );

  always_comb begin
    rx_ready_d = rx_ready_q;
    if (rx_stb)     rx_ready_d = 1'b1;
    else if (rx_rd) rx_ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rx_ready_q <= 1'b0;
      rx_data_q  <= '0;
      own_q      <= OWN_RESET;
      dir_q      <= 1'b0;
    end else begin
      rx_ready_q <= rx_ready_d;
      if (rx_stb)  rx_data_q <= rx_byte;
      if (ctrl_wr) begin
        own_q <= reg_wdata[ADDR_W-1:0];
        dir_q <= reg_wdata[BYTE_W-1];
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      REG_RXD:  reg_rdata = rx_data_q;
      REG_STAT: reg_rdata = BYTE_W'({xmit, tx_ready, rx_ready_q, aas, busy});
      REG_CTRL: reg_rdata = {dir_q, own_q};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_ready,
  input logic tx_pop,
  input logic tx_wr,
  input logic rx_ready,
  input logic rx_stb,
  input logic rx_rd,
  input logic sda_oe,
  input logic scl_s,
  input logic busy,
  input logic aas
);
  AST_TXRDY_RISE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(tx_pop)); // R6
  AST_TXRDY_FALL_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> $past(tx_wr)); // R5
  AST_RXRDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(rx_stb)); // R4
  AST_RXRDY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rx_rd)); // R4
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !$past(scl_s)); // R7
  AST_AAS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    aas |-> busy); // R2
endmodule

bind i2c_slave_port i2cs_checker i_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .tx_pop(tx_pop),
  .tx_wr(tx_wr), .rx_ready(rx_ready_q), .rx_stb(rx_stb), .rx_rd(rx_rd),
  .sda_oe(sda_oe), .scl_s(scl_s), .busy(busy), .aas(aas)
);

// File: tb/test_i2c_slave_port.sv
module test_i2c_slave_port;
  localparam int Q = 6;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk, rst_n, scl, msda, sda_oe, reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic line;
  int ncheck, nerr;

  assign line = msda & ~sda_oe;

  i2c_slave_port i_i2c_slave_port (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .sda_oe(sda_oe),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    ncheck++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, input logic rd, output logic [7:0] d);
    @(negedge clk); reg_rd = rd; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic status(output logic [7:0] s);
    host_rd(2'd2, 1'b0, s);
  endtask

  task automatic bit_x(input logic mb, output logic sb);
    scl = 1'b0; wt(Q/2); msda = mb; wt(Q/2);
    scl = 1'b1; wt(Q); sb = line; wt(Q);
  endtask

  task automatic start_c;
    msda = 1'b0; wt(Q);
  endtask

  task automatic rstart_c;
    scl = 1'b0; wt(Q/2); msda = 1'b1; wt(Q/2);
    scl = 1'b1; wt(Q); msda = 1'b0; wt(Q);
  endtask

  task automatic stop_c;
    scl = 1'b0; wt(Q/2); msda = 1'b0; wt(Q/2);
    scl = 1'b1; wt(Q); msda = 1'b1; wt(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], s);
    bit_x(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, s);
      b[i] = s;
    end
    bit_x(~mack, s);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", ncheck, nerr);
    $finish;
  end

  initial begin
    logic [7:0] s, d, b;
    logic ack;
    ncheck = 0; nerr = 0;
    rst_n = 1'b0; scl = 1'b1; msda = 1'b1;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
    wt(5); rst_n = 1'b1; wt(5);

    status(s);
    check("R1 status after reset", s, 8'h08);
    check("R1 pull-down after reset", {7'd0, sda_oe}, 8'h00);

    // Exhaustive address sweep, unaddressed and addressed-for-write
    for (int a = 0; a < 128; a++) begin
      start_c;
      status(s);
      check("R2 busy after start", {7'd0, s[0]}, 8'h01);
      wr_byte({7'(a), 1'b0}, ack);
      check("R3 address ack", {7'd0, ack}, {7'd0, 7'(a) == OWN});
      status(s);
      check("R3 addressed flag", {7'd0, s[1]}, {7'd0, 7'(a) == OWN});
      check("R5 tx ready regardless of addressing", {7'd0, s[3]}, 8'h01);
      if (7'(a) != OWN) begin
        wr_byte(8'h00, ack);
        check("R3 ignored after mismatch", {7'd0, ack}, 8'h00);
      end
      stop_c;
      status(s);
      check("R2 stop clears busy and addressed", {6'd0, s[1:0]}, 8'h00);
    end

    // Receive with the ignored direction bit set
    host_wr(2'd3, 8'hAA);
    host_rd(2'd3, 1'b0, d);
    check("R9 control readback", d, 8'hAA);
    start_c;
    wr_byte({OWN, 1'b0}, ack);
    check("R9 write addressing with direction bit set", {7'd0, ack}, 8'h01);
    for (int i = 0; i < 16; i++) begin
      b = 8'(i * 37 + 5) ^ 8'(i << 4);
      wr_byte(b, ack);
      check("R4 data ack", {7'd0, ack}, 8'h01);
      status(s);
      check("R4 rx ready set", {7'd0, s[2]}, 8'h01);
      check("R9 receiver mode", {7'd0, s[4]}, 8'h00);
      host_rd(2'd0, 1'b1, d);
      check("R4 rx data", d, b);
      status(s);
      check("R4 rx ready cleared by read", {7'd0, s[2]}, 8'h00);
    end
    stop_c;

    // Transmit-ready fill level and overwrite
    host_wr(2'd1, 8'h11);
    status(s);
    check("R5 one word queued", {7'd0, s[3]}, 8'h01);
    host_wr(2'd1, 8'h22);
    status(s);
    check("R5 second word clears tx ready", {7'd0, s[3]}, 8'h00);
    host_wr(2'd1, 8'h33);
    status(s);
    check("R8 overwrite keeps tx ready low", {7'd0, s[3]}, 8'h00);
    start_c;
    wr_byte({OWN, 1'b1}, ack);
    check("R7 read addressing ack", {7'd0, ack}, 8'h01);
    status(s);
    check("R6 tx ready low after read addressing", {7'd0, s[3]}, 8'h00);
    check("R9 transmitter mode", {7'd0, s[4]}, 8'h01);
    rd_byte(1'b1, b);
    check("R8 newest word sent first", b, 8'h33);
    status(s);
    check("R6 tx ready after byte shifted", {7'd0, s[3]}, 8'h01);
    rd_byte(1'b0, b);
    check("R7 queued order", b, 8'h22);
    host_wr(2'd1, 8'h00);
    bit_x(1'b1, ack);
    check("R7 released after nack", {7'd0, ack}, 8'h01);
    stop_c;

    // Repeated start and empty-queue byte
    start_c;
    wr_byte({OWN, 1'b0}, ack);
    wr_byte(8'h5C, ack);
    check("R10 byte before repeated start ack", {7'd0, ack}, 8'h01);
    rstart_c;
    status(s);
    check("R10 busy kept, addressed cleared", {6'd0, s[1:0]}, 8'h01);
    wr_byte({OWN, 1'b1}, ack);
    check("R10 readdressed ack", {7'd0, ack}, 8'h01);
    status(s);
    check("R10 addressed again", {7'd0, s[1]}, 8'h01);
    rd_byte(1'b1, b);
    check("R7 queued word", b, 8'h00);
    rd_byte(1'b0, b);
    check("R11 empty queue sends ones", b, 8'hFF);
    stop_c;
    host_rd(2'd0, 1'b1, d);
    check("R10 rx data before repeated start", d, 8'h5C);
    status(s);
    check("R2 idle after stop", {6'd0, s[1:0]}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", ncheck, nerr);
    $finish;
  end
endmodule